// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable behavioural model of a small single-port synchronous SRAM. It has a 32-bit word split into four 8-bit lanes. On every rising clock edge it registers the address, the write controls and the word present on a shared bidirectional data bus. A cycle either writes some subset of the four lanes or reads the whole word.

Writes have two levels of control. A global write strobe forces all four lanes. A byte-write strobe arms the four per-lane strobes, which otherwise have no effect. Read data passes through an output pipeline register and appears on the shared bus one clock after its address is registered. The bus is driven only while the output enable is asserted, and only when the previous registered cycle was a read. The array depth is set by an address-width parameter and is kept small for simulation.

Top module: `byte_write_sram`

## Requirements
- R1: Lane a is dq bits [7:0] and is controlled by bw_ni[0]. Lane b is bits [15:8] with bw_ni[1], lane c is bits [23:16] with bw_ni[2], and lane d is bits [31:24] with bw_ni[3].
- R2: In a cycle with gw_ni high and bwe_ni low, each lane whose bw_ni bit is low takes the registered bus data for that lane. Every other lane of that word keeps its old contents.
- R3: While gw_ni and bwe_ni are both high, bw_ni has no effect. The cycle is a read and no lane of the array changes.
- R4: A cycle with gw_ni low writes all four lanes, whatever the values of bwe_ni and bw_ni.
- R5: Address, controls and bus data are captured on the rising clock edge. The data of a read appears on dq_io after the next rising edge and holds until the edge after that.
- R6: dq_io is driven only while oe_ni is low and the previously registered cycle was a read. It is high impedance after any write cycle (including a byte-write cycle with no lane selected), while oe_ni is high, and during and just after reset.
- R7: A read registered in the cycle directly after a write to the same address returns the newly written lanes merged with the lanes that were left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr_i | input | ADDR_W | Word address |
| gw_ni | input | 1 | Global write strobe, active low, writes all lanes |
| bwe_ni | input | 1 | Byte-write strobe, active low, arms bw_ni |
| bw_ni | input | DATA_W/LANE_W | Per-lane write strobes, active low |
| oe_ni | input | 1 | Output enable, active low |
| dq_io | inout | DATA_W | Shared write data in and read data out |

## Verification
The bench builds the block with ADDR_W = 3, so the eight-word array can be filled completely, read back in full and then hit repeatedly by a long mixed sequence. The behavioural model in the bench tracks every lane mask through every combination of global write, byte-write strobe and lane strobe. This covers back-to-back write-then-read and read-then-write on the same word, as well as byte-write cycles that select no lane. A pull-up on the bus turns high impedance into a visible all-ones value, so the drive rule after writes, with the output enable high, and during reset is compared on every cycle.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 32;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10
  } cyc_e;
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  output logic              act_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] din_o,
  output logic              gw_no,
  output logic              bwe_no,
  output logic [LANES-1:0]  bw_no
);
  // act_o marks that at least one real cycle was captured since reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      addr_o <= '0;
      din_o  <= '0;
      gw_no  <= 1'b1;
      bwe_no <= 1'b1;
      bw_no  <= '1;
    end else begin
      act_o  <= 1'b1;
      addr_o <= addr_i;
      din_o  <= din_i;
      gw_no  <= gw_ni;
      bwe_no <= bwe_ni;
      bw_no  <= bw_ni;
    end
  end
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             act_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] lane_we_o,
  output logic             rd_o,
  output cyc_e             cyc_o
);
  logic armed;
  assign armed = act_i && !bwe_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // global strobe overrides; lane strobes count only when armed
    assign lane_we_o[g] = act_i && (!gw_ni || (armed && !bw_ni[g]));
  end

  always_comb begin
    if (!act_i)                cyc_o = CYC_NONE;
    else if (gw_ni && bwe_ni)  cyc_o = CYC_READ;
    else                       cyc_o = CYC_WRITE;
  end

  assign rd_o = (cyc_o == CYC_READ);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES-1:0]          lane_we_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o,
  output logic              drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else begin
      valid_o <= rd_i;
      if (rd_i) dout_o <= rdata_i;
    end
  end

  assign drive_o = valid_o && !oe_ni;
endmodule

// File: rtl/byte_write_sram.sv
module byte_write_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       gw_ni,
  input  logic                       bwe_ni,
  input  logic [DATA_W/LANE_W-1:0]   bw_ni,
  input  logic                       oe_ni,
  inout  wire  [DATA_W-1:0]          dq_io
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              gw_q;
  logic              bwe_q;
  logic [LANES-1:0]  bw_q;
  logic [LANES-1:0]  lane_we;
  logic              rd_q;
  cyc_e              cyc_q;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] dout;
  logic              out_valid;
  logic              drive_en;

  sram_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .din_i  (dq_io),
    .gw_ni  (gw_ni),
    .bwe_ni (bwe_ni),
    .bw_ni  (bw_ni),
    .act_o  (act_q),
    .addr_o (addr_q),
    .din_o  (din_q),
    .gw_no  (gw_q),
    .bwe_no (bwe_q),
    .bw_no  (bw_q)
  );

  sram_wr_ctrl #(.LANES(LANES)) u_ctrl (
    .act_i     (act_q),
    .gw_ni     (gw_q),
    .bwe_ni    (bwe_q),
    .bw_ni     (bw_q),
    .lane_we_o (lane_we),
    .rd_o      (rd_q),
    .cyc_o     (cyc_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk_i     (clk_i),
    .addr_i    (addr_q),
    .wdata_i   (din_q),
    .lane_we_i (lane_we),
    .rdata_o   (rdata)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_q),
    .rdata_i (rdata),
    .oe_ni   (oe_ni),
    .dout_o  (dout),
    .valid_o (out_valid),
    .drive_o (drive_en)
  );

  assign dq_io = drive_en ? dout : 'z;
endmodule

// File: rtl/byte_write_sram_chk.sv
module byte_write_sram_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              act_q,
  input logic              gw_q,
  input logic              bwe_q,
  input logic [LANES-1:0]  bw_q,
  input logic [LANES-1:0]  lane_we,
  input logic              rd_q,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] dout,
  input logic              out_valid,
  input logic              drive_en,
  input logic              oe_ni
);
  p_all_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !gw_q) |-> (lane_we == '1));

  p_strobes_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && gw_q && bwe_q) |-> (lane_we == '0));

  p_lane_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && gw_q && !bwe_q) |-> (lane_we == ~bw_q));

  p_read_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> out_valid);

  p_read_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> (dout == $past(rdata)));

  p_no_valid_after_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |=> !out_valid);

  p_drive_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en |-> ($past(rd_q) && !oe_ni));
endmodule

bind byte_write_sram byte_write_sram_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .act_q     (act_q),
  .gw_q      (gw_q),
  .bwe_q     (bwe_q),
  .bw_q      (bw_q),
  .lane_we   (lane_we),
  .rd_q      (rd_q),
  .rdata     (rdata),
  .dout      (dout),
  .out_valid (out_valid),
  .drive_en  (drive_en),
  .oe_ni     (oe_ni)
);

// File: tb/byte_write_sram_tb_top.sv
module byte_write_sram_tb_top;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1;
  logic          bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic          oe_n = 1'b1;
  logic          tb_en = 1'b0;
  logic [DW-1:0] tb_dat = '0;
  wire  [DW-1:0] dq;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [DW-1:0] ref_mem [8];
  logic          p_rd = 1'b0, p_wr = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [3:0]    p_mask = '0;
  logic [DW-1:0] p_data = '0;
  logic          e_valid = 1'b0;
  logic [DW-1:0] e_out = '0;

  pullup (dq);
  assign dq = tb_en ? tb_dat : 'z;

  always #10 clk = ~clk;

  byte_write_sram #(.ADDR_W(AW)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .gw_ni  (gw_n),
    .bwe_ni (bwe_n),
    .bw_ni  (bw_n),
    .oe_ni  (oe_n),
    .dq_io  (dq)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s dq=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, compare bus, advance model at posedge
  task automatic step(input string req, input logic [AW-1:0] a, input logic g,
                      input logic b, input logic [3:0] lanes, input logic [DW-1:0] d,
                      input logic oe);
    logic wr;
    @(negedge clk);
    wr     = !g || !b;
    addr   = a;
    gw_n   = g;
    bwe_n  = b;
    bw_n   = lanes;
    oe_n   = wr ? 1'b1 : oe;
    tb_en  = wr;
    tb_dat = d;
    #1;
    if (!wr) check(req, dq, (e_valid && !oe_n) ? e_out : ONES);
    @(posedge clk);
    if (p_rd) begin
      e_out   = ref_mem[p_addr];
      e_valid = 1'b1;
    end else begin
      e_valid = 1'b0;
    end
    if (p_wr)
      for (int i = 0; i < 4; i++)
        if (p_mask[i]) ref_mem[p_addr][i*8 +: 8] = p_data[i*8 +: 8];
    p_rd   = g && b;
    p_wr   = wr;
    p_addr = a;
    p_data = d;
    p_mask = !g ? 4'hF : (!b ? ~lanes : 4'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_mem[i] = '0;
    // reset: bus must float even with output enable low (R6)
    oe_n = 1'b0;
    #35;
    check("R6", dq, ONES);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R6", dq, ONES);

    // R4: fill with global write; bwe/bw values must not matter
    for (int i = 0; i < 8; i++)
      step("R4", AW'(i), 1'b0, i[0], 4'(i * 5), 32'hA0B0C0D0 ^ (i * 32'h01010101), 1'b0);
    // R5: full read back, back-to-back
    for (int i = 0; i < 8; i++) step("R5", AW'(i), 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R5", 3'd0, 1'b1, 1'b1, 4'hF, '0, 1'b0);

    // R1/R2/R7: lanes a and c only, then immediate read of same word
    step("R2", 3'd2, 1'b1, 1'b0, 4'b1010, 32'h11223344, 1'b0);
    step("R7", 3'd2, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R1", 3'd2, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    // lane d alone (bit 3)
    step("R1", 3'd5, 1'b1, 1'b0, 4'b0111, 32'h5A000000, 1'b0);
    step("R7", 3'd5, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R1", 3'd5, 1'b1, 1'b1, 4'hF, '0, 1'b0);

    // R3: strobes low but unarmed -> read, word unchanged
    step("R3", 3'd3, 1'b1, 1'b1, 4'h0, 32'h0BADBEEF, 1'b0);
    step("R3", 3'd3, 1'b1, 1'b1, 4'h0, '0, 1'b0);
    step("R3", 3'd3, 1'b1, 1'b1, 4'hF, '0, 1'b0);

    // R6: armed write with no lane selected -> no change, bus floats after
    step("R6", 3'd4, 1'b1, 1'b0, 4'hF, 32'h12345678, 1'b0);
    step("R6", 3'd4, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R6", 3'd4, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    // R6: output enable high hides read data
    step("R6", 3'd1, 1'b1, 1'b1, 4'hF, '0, 1'b1);
    step("R6", 3'd1, 1'b1, 1'b1, 4'hF, '0, 1'b1);
    step("R6", 3'd1, 1'b1, 1'b1, 4'hF, '0, 1'b0);

    // read then write same word: read returns old data (R5)
    step("R5", 3'd6, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R5", 3'd6, 1'b0, 1'b1, 4'hF, 32'h01020304, 1'b0);
    step("R7", 3'd6, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R7", 3'd6, 1'b1, 1'b1, 4'hF, '0, 1'b0);

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] d;
      logic [2:0] kind;
      d = $urandom;
      if (d == ONES) d = '0;
      kind = 3'($urandom);
      step("R5", AW'($urandom), kind != 3'd0 && kind != 3'd1,
           kind[2] && kind[1], 4'($urandom), d, 1'($urandom % 4 == 0));
    end
    step("R5", 3'd0, 1'b1, 1'b1, 4'hF, '0, 1'b0);
    step("R5", 3'd0, 1'b1, 1'b1, 4'hF, '0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule